// File: doc/BRIEF.md
# Dual Interval Timer Counter

A memory-mapped peripheral with one or two 32-bit timer channels. The number of channels is set by a build parameter. A simple 32-bit register bus with word-only access reaches each channel's registers. Every channel owns a bank of four word slots: control/status, load value, live count and a spare scratch word.

Software programs a load value and then writes the control word with the run bit set. This copies the load value into the counter. From the next cycle the counter moves one step per clock, either down toward zero or up toward all-ones. When it reaches the end of its range, the channel raises its interrupt flag. It then either reloads and keeps counting, or stops and drops its run bit.

One level-sensitive interrupt line is shared by all channels. It is the OR of each channel's flag gated by that channel's interrupt enable. Writing the control word always clears the flag.

Top module: `interval_timer`

## Requirements
- R1: After synchronous active-high reset, every register of every channel reads zero, no channel counts and `irq_o` is low.
- R2: The word address is split as follows. Bit 2 picks the channel and bits 1:0 pick the register: 0 control/status, 1 load, 2 count, 3 spare. Load and spare read back what was last written, and a write to one channel leaves the other channel untouched.
- R3: The control word keeps bits 10:0 and reads zero above them. The flag (bit 8) always reads 0 after any control write, whatever was written there. For example, writing 0xFFFFFFFF reads back 0x6FF.
- R4: A control write with bit 7 (run) set copies the load value into the count. Counting begins on the following cycle.
- R5: With bit 1 = 1 (down), a running count falls by one per cycle. In the cycle after it reads 0, the terminal event sets the flag.
- R6: With bit 1 = 0 (up), a running count rises by one per cycle. In the cycle after it reads 0xFFFFFFFF, the terminal event sets the flag.
- R7: At a terminal event with bit 4 (reload) set, the count takes the load value and keeps running. With bit 4 clear, the count holds and bit 7 clears.
- R8: A control write with bit 7 clear freezes the count at its value. A later write with bit 7 set restarts from the load value.
- R9: `irq_o` is high exactly when some channel has both its flag (bit 8) and its interrupt enable (bit 6) set.
- R10: Writes to the count register have no effect.
- R11: With one channel configured, addresses with bit 2 set read zero and ignore writes.
- R12: Control bits 0, 2, 3, 5, 9 and 10 are stored and read back, but they do not change counting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for the addressed word |
| bus_addr | input | 3 | Word address (channel, register) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Shared level interrupt |

## Verification
The assertions assume one bus write per cycle. They also assume a write touches a single register, so a load write and a control write never land in the same cycle. Their step checks assume that a control write takes precedence over a terminal event in the same cycle. The stimulus holds to this by design: each write is a one-cycle strobe followed by its own cycle, and reads never assert the strobe. Load values are chosen so that terminal events fall inside short read windows and never coincide with the control writes that are checked.

// File: rtl/timer_pkg.sv
package timer_pkg;
  parameter int CNT_W = 32;
  parameter int CSR_W = 11;

  localparam int B_DOWN   = 1;
  localparam int B_RELOAD = 4;
  localparam int B_IE     = 6;
  localparam int B_RUN    = 7;
  localparam int B_FLAG   = 8;

  localparam logic [1:0] OFS_CSR   = 2'd0;
  localparam logic [1:0] OFS_LOAD  = 2'd1;
  localparam logic [1:0] OFS_COUNT = 2'd2;
  localparam logic [1:0] OFS_SPARE = 2'd3;

  // next value of a running counter
  function automatic logic [CNT_W-1:0] step_count(input logic [CNT_W-1:0] c,
                                                  input logic down);
    return down ? c - 1'b1 : c + 1'b1;
  endfunction

  // end of the counting range for the given direction
  function automatic logic at_end(input logic [CNT_W-1:0] c, input logic down);
    return down ? (c == '0) : (c == '1);
  endfunction
endpackage

// File: rtl/timer_channel.sv
module timer_channel
  import timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             csr_we,
  input  logic             load_we,
  input  logic             spare_we,
  input  logic [CNT_W-1:0] wdata,
  output logic [CSR_W-1:0] csr_q,
  output logic [CNT_W-1:0] load_q,
  output logic [CNT_W-1:0] count_q,
  output logic [CNT_W-1:0] spare_q,
  output logic             term_evt,
  output logic             irq_req
);
  logic run, down;
  assign run      = csr_q[B_RUN];
  assign down     = csr_q[B_DOWN];
  assign term_evt = run && at_end(count_q, down);
  assign irq_req  = csr_q[B_FLAG] & csr_q[B_IE];

  localparam logic [CSR_W-1:0] FLAG_MASK = ~(CSR_W'(1) << B_FLAG);

  always_ff @(posedge clk) begin
    if (rst) begin
      csr_q   <= '0;
      load_q  <= '0;
      count_q <= '0;
      spare_q <= '0;
    end else begin
      if (load_we)  load_q  <= wdata;
      if (spare_we) spare_q <= wdata;
      if (csr_we) begin
        csr_q <= wdata[CSR_W-1:0] & FLAG_MASK;
        if (wdata[B_RUN]) count_q <= load_q;
      end else if (term_evt) begin
        csr_q[B_FLAG] <= 1'b1;
        if (csr_q[B_RELOAD]) count_q <= load_q;
        else                 csr_q[B_RUN] <= 1'b0;
      end else if (run) begin
        count_q <= step_count(count_q, down);
      end
    end
  end

  // R3
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    csr_we |=> !csr_q[B_FLAG]);
  // R4
  start_load_chk: assert property (@(posedge clk) disable iff (rst)
    (csr_we && wdata[B_RUN] && !load_we) |=> count_q == $past(load_q));
  // R5
  down_step_chk: assert property (@(posedge clk) disable iff (rst)
    (run && down && !term_evt && !csr_we) |=> count_q == $past(count_q) - 1);
  // R6
  term_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (term_evt && !csr_we) |=> csr_q[B_FLAG]);
  // R7
  reload_chk: assert property (@(posedge clk) disable iff (rst)
    (term_evt && !csr_we && csr_q[B_RELOAD]) |=> count_q == $past(load_q));
  // R7
  stop_chk: assert property (@(posedge clk) disable iff (rst)
    (term_evt && !csr_we && !csr_q[B_RELOAD]) |=> (!csr_q[B_RUN] && $stable(count_q)));
  // R8
  freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !csr_we) |=> $stable(count_q));
endmodule

// File: rtl/timer_irq_merge.sv
module timer_irq_merge #(
  parameter int N = 2
) (
  input  logic [N-1:0] req,
  output logic         irq
);
  assign irq = |req;
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import timer_pkg::*;
#(
  parameter int CHANNELS = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_we,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq_o
);
  logic [CSR_W-1:0] csr_w   [CHANNELS];
  logic [CNT_W-1:0] load_w  [CHANNELS];
  logic [CNT_W-1:0] count_w [CHANNELS];
  logic [CNT_W-1:0] spare_w [CHANNELS];
  logic [CHANNELS-1:0] term_w, irq_req_w;

  logic [1:0] ofs;
  assign ofs = bus_addr[1:0];

  for (genvar i = 0; i < CHANNELS; i++) begin : g_ch
    logic hit;
    assign hit = bus_we && (bus_addr[2] == 1'(i));
    timer_channel u_ch (
      .clk     (clk),
      .rst     (rst),
      .csr_we  (hit && ofs == OFS_CSR),
      .load_we (hit && ofs == OFS_LOAD),
      .spare_we(hit && ofs == OFS_SPARE),
      .wdata   (bus_wdata),
      .csr_q   (csr_w[i]),
      .load_q  (load_w[i]),
      .count_q (count_w[i]),
      .spare_q (spare_w[i]),
      .term_evt(term_w[i]),
      .irq_req (irq_req_w[i])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < CHANNELS; i++) begin
      if (bus_addr[2] == 1'(i)) begin
        unique case (ofs)
          OFS_CSR:   bus_rdata = {{(32-CSR_W){1'b0}}, csr_w[i]};
          OFS_LOAD:  bus_rdata = load_w[i];
          OFS_COUNT: bus_rdata = count_w[i];
          default:   bus_rdata = spare_w[i];
        endcase
      end
    end
  end

  timer_irq_merge #(.N(CHANNELS)) u_irq (
    .req(irq_req_w),
    .irq(irq_o)
  );

  // R9
  irq_source_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (irq_req_w != '0));
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!irq_o && term_w == '0));
endmodule

// File: tb/interval_timer_test.sv
`timescale 1ns/1ps
module interval_timer_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_we = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rdata, rdata1;
  logic irq, irq1;

  always #2.5 clk = ~clk;

  interval_timer #(.CHANNELS(2)) uut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata), .irq_o(irq));

  interval_timer #(.CHANNELS(1)) uut_single (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata1), .irq_o(irq1));

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done = 0;

  // scoreboard queues: kind 0 rdata, 1 irq, 2 single rdata, 3 single irq
  int          q_kind[$];
  logic [31:0] q_exp[$];
  string       q_tag[$];

  task automatic push(input int kind, input logic [31:0] exp, input string tag);
    q_kind.push_back(kind);
    q_exp.push_back(exp);
    q_tag.push_back(tag);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a; push(0, exp, tag);
    @(posedge clk); #1;
  endtask

  task automatic rd1(input logic [2:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a; push(2, exp, tag);
    @(posedge clk); #1;
  endtask

  task automatic chk_irq(input int kind, input logic exp, input string tag);
    push(kind, {31'd0, exp}, tag);
    @(posedge clk); #1;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin @(posedge clk); #1; end
  endtask

  // monitor
  always @(negedge clk) begin
    if (q_kind.size() > 0) begin
      int kind;
      logic [31:0] exp, act;
      string tag;
      kind = q_kind.pop_front();
      exp  = q_exp.pop_front();
      tag  = q_tag.pop_front();
      case (kind)
        0: act = rdata;
        1: act = {31'd0, irq};
        2: act = rdata1;
        default: act = {31'd0, irq1};
      endcase
      n_checks++;
      if (act !== exp) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;

    // R1 reset state
    for (int a = 0; a < 8; a++) rd(3'(a), 32'h0, "R1 reset register");
    chk_irq(1, 1'b0, "R1 irq after reset");
    chk_irq(3, 1'b0, "R1 single irq after reset");

    // R2 load and spare read back; R10 count write ignored
    wr(3'd1, 32'h10);
    rd(3'd1, 32'h10, "R2 load readback");
    wr(3'd3, 32'hDEADBEEF);
    rd(3'd3, 32'hDEADBEEF, "R2 spare readback");
    wr(3'd2, 32'h5);
    rd(3'd2, 32'h0, "R10 count write ignored");

    // R3 stored width and flag always cleared
    wr(3'd1, 32'h0);
    wr(3'd0, 32'hFFFFFFFF);
    rd(3'd0, 32'h6FF, "R3 control keeps 10:0 with flag clear");
    wr(3'd0, 32'h0);
    rd(3'd0, 32'h0, "R3 control cleared");

    // R4 R5 R7 down, no reload, stops
    wr(3'd1, 32'd2);
    wr(3'd0, 32'hC2);
    rd(3'd2, 32'd2, "R4 count takes load");
    rd(3'd2, 32'd1, "R5 down step");
    rd(3'd2, 32'd0, "R5 reaches zero");
    rd(3'd2, 32'd0, "R7 holds after stop");
    rd(3'd0, 32'h142, "R7 run cleared, R5 flag set");
    chk_irq(1, 1'b1, "R9 flag and enable give irq");
    wr(3'd0, 32'h142);
    chk_irq(1, 1'b0, "R9 irq drops after flag clear");
    rd(3'd0, 32'h42, "R3 written flag not stored");

    // R6 R7 up with reload, interrupt disabled
    wr(3'd1, 32'hFFFFFFFD);
    wr(3'd0, 32'h90);
    rd(3'd2, 32'hFFFFFFFD, "R6 start");
    rd(3'd2, 32'hFFFFFFFE, "R6 up step");
    rd(3'd2, 32'hFFFFFFFF, "R6 all ones");
    rd(3'd2, 32'hFFFFFFFD, "R7 reload on terminal");
    rd(3'd0, 32'h190, "R6 flag set, run kept");
    chk_irq(1, 1'b0, "R9 flag without enable");
    wr(3'd0, 32'h0);

    // R8 freeze and restart, R10 ignored while frozen
    wr(3'd1, 32'd100);
    wr(3'd0, 32'hD2);
    rd(3'd2, 32'd100, "R8 start");
    rd(3'd2, 32'd99, "R8 counting");
    wr(3'd0, 32'h52);
    rd(3'd2, 32'd98, "R8 frozen");
    rd(3'd2, 32'd98, "R8 still frozen");
    wr(3'd2, 32'd7);
    rd(3'd2, 32'd98, "R10 count write while frozen");
    wr(3'd0, 32'hD2);
    rd(3'd2, 32'd100, "R8 restart from load");
    wr(3'd0, 32'h0);

    // R12 inert bits
    wr(3'd1, 32'd3);
    wr(3'd0, 32'h6AF);
    rd(3'd2, 32'd3, "R12 start unaffected");
    rd(3'd2, 32'd2, "R12 down step unaffected");
    rd(3'd0, 32'h6AF, "R12 inert bits stored");
    wr(3'd0, 32'h0);

    // R2 channel 1, R11 single-channel build
    wr(3'd5, 32'd1);
    wr(3'd4, 32'hD2);
    rd(3'd6, 32'd1, "R2 channel 1 start");
    rd(3'd6, 32'd0, "R2 channel 1 step");
    rd(3'd6, 32'd1, "R7 channel 1 reload");
    rd(3'd4, 32'h1D2, "R2 channel 1 flag");
    rd(3'd1, 32'd3, "R2 channel 0 load untouched");
    chk_irq(1, 1'b1, "R9 channel 1 irq");
    rd1(3'd5, 32'h0, "R11 single ignores channel 1 load");
    rd1(3'd4, 32'h0, "R11 single ignores channel 1 control");
    rd1(3'd1, 32'd3, "R11 single channel 0 works");
    chk_irq(3, 1'b0, "R11 single irq quiet");
    wr(3'd4, 32'h0);
    chk_irq(1, 1'b0, "R9 irq cleared");

    // R9 OR across channels
    wr(3'd1, 32'd0);
    wr(3'd0, 32'hC2);
    wr(3'd5, 32'd0);
    wr(3'd4, 32'hC2);
    idle(2);
    chk_irq(1, 1'b1, "R9 both flagged");
    wr(3'd0, 32'h42);
    chk_irq(1, 1'b1, "R9 channel 1 still holds irq");
    wr(3'd4, 32'h42);
    chk_irq(1, 1'b0, "R9 all cleared");

    idle(2);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule